// File: doc/BRIEF.md
# Serial Two-Wire EEPROM Slave Controller

This block is the digital core of a two-wire (I2C) serial EEPROM. It sees the bus clock and data lines through synchronisers and frames each transfer between a START and a STOP. It answers only to its own select byte. That byte carries a fixed device-type nibble and three strap bits that tell apart up to eight devices on the same bus. The block drives the data line low only through an open-drain enable output.

A write transaction gives a two-byte address, most significant byte first, and then any number of data bytes. The data bytes gather in a page buffer, and the offset within the page wraps. The STOP that closes the transaction starts a timed internal write cycle, which copies the buffered bytes into the byte array. While that cycle runs, the device refuses its select byte, so a host can poll for completion. A write-control input blocks all writes. When it is high, the select byte and the address bytes are still acknowledged, but every data byte is refused.

Reads come in three forms: from the current address, from a random address (an address-only write followed by a repeated START), or as a sequential run. A sequential run carries on for as long as the host acknowledges each byte. The array has 2^MEM_AW bytes, and higher address bits alias onto it; setting MEM_AW to 16 gives the full 64K × 8 map.

Top module: `i2c_eeprom_slave`

## Requirements
- R1: After reset the data-line enable is low, the device is idle and no write cycle is running, so the first select byte is acknowledged.
- R2: A select byte is acknowledged only when bits 7..4 equal 1010b and bits 3..1 equal strap_i; bit 0 is read(1)/write(0). A non-matching select is not acknowledged, and every later byte is ignored (not acknowledged) until the next START or STOP.
- R3: The data-line enable changes only while SCL is low.
- R4: The two address bytes (high then low) are each acknowledged. A random read, made of an address-only write, a repeated START and a read select, returns the byte stored at that address.
- R5: With write control low, each data byte is acknowledged and placed at the low PAGE_W bits of the address pointer. Those bits wrap within the page of 2^PAGE_W bytes (default 128) while the upper bits stay fixed, and a later byte at the same offset replaces an earlier one. The page is committed to the array after STOP.
- R6: A STOP that follows at least one accepted data byte starts a write cycle lasting WCYC_CLKS clocks. During it the select byte is not acknowledged; after it, the select byte is acknowledged again.
- R7: With write control high, the select and address bytes are acknowledged, the first data byte is not, memory is unchanged, and no write cycle starts.
- R8: A write transaction with no data bytes starts no write cycle.
- R9: A current-address read starts one past the last byte read, or at the wrapped position after the last byte written.
- R10: During a sequential read each host acknowledge advances the 16-bit address, wrapping from 0xFFFF to 0x0000. A host not-acknowledge ends the read and the data line is released.
- R11: A repeated START after data bytes discards them: no write cycle starts and memory is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe_o | output | 1 | High pulls the data line low (open drain) |
| strap_i | input | 3 | Device address straps, compared with select bits 3..1; tie low if unused |
| wr_protect_i | input | 1 | High blocks all writes; tie low if unused |

## Verification
The select decoder is swept over all eight strap codes and all sixteen type nibbles. Exactly one combination may draw an acknowledge, and that separates a full compare from a partial one. Page writes are swept over every start offset in a small page, with lengths from shorter than a page to longer than one. Reading back whole pages shows whether the offset wraps, whether the upper address is held, and whether late bytes overwrite early ones. Polls taken right after a STOP and again after the write time tell a real write cycle apart from the paths that must start none: protected, address-only and restart-abandoned writes. The bench also reads across 0xFFFF and then does a current-address read, which checks the full-width increment and the pointer rule.

// File: rtl/eeprom_pkg.sv
package eeprom_pkg;
   localparam int ADDR_W = 16;
   localparam int DATA_W = 8;
   localparam logic [3:0] DEV_TYPE = 4'b1010;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_DEV,
      ST_AHI,
      ST_ALO,
      ST_WDAT,
      ST_RDAT,
      ST_SKIP
   } bus_st_t;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_s,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);
   logic [STAGES-1:0] scl_sh, sda_sh;
   logic scl_q, sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_sh <= '1;
         sda_sh <= '1;
         scl_q  <= 1'b1;
         sda_q  <= 1'b1;
      end else begin
         scl_sh <= {scl_sh[STAGES-2:0], scl_i};
         sda_sh <= {sda_sh[STAGES-2:0], sda_i};
         scl_q  <= scl_sh[STAGES-1];
         sda_q  <= sda_sh[STAGES-1];
      end
   end

   assign scl_s     = scl_sh[STAGES-1];
   assign sda_s     = sda_sh[STAGES-1];
   assign scl_rise  = scl_s & ~scl_q;
   assign scl_fall  = ~scl_s & scl_q;
   assign start_det = scl_s & scl_q & sda_q & ~sda_s;
   assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/page_buf.sv
module page_buf #(
   parameter int PAGE_W = 7,
   parameter int DW     = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              we,
   input  logic [PAGE_W-1:0] waddr,
   input  logic [DW-1:0]     wdata,
   input  logic [PAGE_W-1:0] ridx,
   output logic [DW-1:0]     rdata,
   output logic              rvalid
);
   localparam int NBYTES = 1 << PAGE_W;

   logic [DW-1:0]     store [NBYTES];
   logic [NBYTES-1:0] filled;

   always_ff @(posedge clk) begin
      if (we) store[waddr] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   filled <= '0;
      else if (clr) filled <= '0;
      else if (we)  filled[waddr] <= 1'b1;
   end

   assign rdata  = store[ridx];
   assign rvalid = filled[ridx];
endmodule

// File: rtl/write_cycle.sv
module write_cycle #(
   parameter int WCYC_CLKS = 1250000,
   parameter int PAGE_W    = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              go,
   output logic              busy,
   output logic              step_en,
   output logic [PAGE_W-1:0] step_idx
);
   localparam int CW = $clog2(WCYC_CLKS + 1);
   localparam logic [CW-1:0] LAST = CW'(WCYC_CLKS - 1);
   localparam logic [CW-1:0] NBUF = CW'(1 << PAGE_W);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         cnt  <= '0;
      end else if (busy) begin
         if (cnt == LAST) busy <= 1'b0;
         cnt <= cnt + CW'(1);
      end else if (go) begin
         busy <= 1'b1;
         cnt  <= '0;
      end
   end

   assign step_en  = busy && (cnt < NBUF);
   assign step_idx = cnt[PAGE_W-1:0];
endmodule

// File: rtl/byte_mem.sv
module byte_mem #(
   parameter int AW = 11,
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);
   logic [DW-1:0] arr [1 << AW];

   always_ff @(posedge clk) begin
      if (we) arr[waddr] <= wdata;
      rdata <= arr[raddr];
   end
endmodule

// File: rtl/i2c_eeprom_slave.sv
module i2c_eeprom_slave
   import eeprom_pkg::*;
#(
   parameter int MEM_AW      = 11,
   parameter int PAGE_W      = 7,
   parameter int WCYC_CLKS   = 1250000,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       scl_i,
   input  logic       sda_i,
   output logic       sda_oe_o,
   input  logic [2:0] strap_i,
   input  logic       wr_protect_i
);
   localparam int PAGE_BYTES = 1 << PAGE_W;
   localparam int BASE_W     = ADDR_W - PAGE_W;

   if (PAGE_W < 1 || PAGE_W > 8) begin : g_bad_page
      $error("PAGE_W must lie in 1..8");
   end
   if (MEM_AW < PAGE_W || MEM_AW > ADDR_W) begin : g_bad_mem
      $error("MEM_AW must lie in PAGE_W..16");
   end
   if (WCYC_CLKS < PAGE_BYTES) begin : g_bad_wcyc
      $error("WCYC_CLKS must cover one clock per page byte");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

   i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_i     (scl_i),
      .sda_i     (sda_i),
      .scl_s     (scl_s),
      .sda_s     (sda_s),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det)
   );

   bus_st_t            st, nxt_st;
   logic [3:0]         bitc;
   logic [6:0]         shreg;
   logic               ack_en;
   logic               sda_oe;
   logic               pend;
   logic [7:0]         addr_hi;
   logic [ADDR_W-1:0]  aptr;
   logic [BASE_W-1:0]  cbase;
   logic [DATA_W-1:0]  rd_q;

   logic [7:0]         byte_in;
   logic               rx_st, byte_done, sel_ok, buf_we, buf_clr, wc_go;
   logic               busy, step_en, buf_vld, mem_we;
   logic [PAGE_W-1:0]  step_idx;
   logic [DATA_W-1:0]  buf_q;

   assign byte_in   = {shreg, sda_s};
   assign rx_st     = (st == ST_DEV) || (st == ST_AHI) || (st == ST_ALO) || (st == ST_WDAT);
   assign byte_done = scl_rise && rx_st && (bitc == 4'd7);
   assign sel_ok    = (byte_in[7:4] == DEV_TYPE) && (byte_in[3:1] == strap_i) && !busy;
   assign buf_we    = byte_done && (st == ST_WDAT) && !wr_protect_i;
   assign buf_clr   = byte_done && (st == ST_ALO);
   assign wc_go     = stop_det && pend;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         nxt_st  <= ST_IDLE;
         bitc    <= '0;
         shreg   <= '0;
         ack_en  <= 1'b0;
         sda_oe  <= 1'b0;
         pend    <= 1'b0;
         addr_hi <= '0;
         aptr    <= '0;
         cbase   <= '0;
      end else if (start_det) begin
         st     <= ST_DEV;
         bitc   <= '0;
         sda_oe <= 1'b0;
         pend   <= 1'b0;
      end else if (stop_det) begin
         st     <= ST_IDLE;
         bitc   <= '0;
         sda_oe <= 1'b0;
         pend   <= 1'b0;
         if (pend) cbase <= aptr[ADDR_W-1:PAGE_W];
      end else begin
         if (scl_fall) begin
            if (st == ST_RDAT)
               sda_oe <= (bitc == 4'd8) ? 1'b0 : ~rd_q[3'd7 - bitc[2:0]];
            else if (rx_st && bitc == 4'd8)
               sda_oe <= ack_en;
            else
               sda_oe <= 1'b0;
         end
         if (scl_rise) begin
            if (rx_st) begin
               if (bitc == 4'd8) begin
                  bitc <= '0;
                  st   <= nxt_st;
               end else begin
                  shreg <= byte_in[6:0];
                  bitc  <= bitc + 4'd1;
                  if (bitc == 4'd7) begin
                     case (st)
                        ST_DEV: begin
                           ack_en <= sel_ok;
                           if (!sel_ok)        nxt_st <= ST_SKIP;
                           else if (byte_in[0]) nxt_st <= ST_RDAT;
                           else                 nxt_st <= ST_AHI;
                        end
                        ST_AHI: begin
                           addr_hi <= byte_in;
                           ack_en  <= 1'b1;
                           nxt_st  <= ST_ALO;
                        end
                        ST_ALO: begin
                           aptr   <= {addr_hi, byte_in};
                           ack_en <= 1'b1;
                           nxt_st <= ST_WDAT;
                        end
                        ST_WDAT: begin
                           if (wr_protect_i) begin
                              ack_en <= 1'b0;
                              nxt_st <= ST_SKIP;
                              pend   <= 1'b0;
                           end else begin
                              ack_en <= 1'b1;
                              nxt_st <= ST_WDAT;
                              pend   <= 1'b1;
                              aptr   <= {aptr[ADDR_W-1:PAGE_W], aptr[PAGE_W-1:0] + PAGE_W'(1)};
                           end
                        end
                        default: ;
                     endcase
                  end
               end
            end else if (st == ST_RDAT) begin
               if (bitc == 4'd8) begin
                  bitc <= '0;
                  aptr <= aptr + 16'd1;
                  if (sda_s) st <= ST_SKIP;
               end else begin
                  bitc <= bitc + 4'd1;
               end
            end
         end
      end
   end

   assign sda_oe_o = sda_oe;

   page_buf #(.PAGE_W(PAGE_W), .DW(DATA_W)) u_pbuf (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (buf_clr),
      .we     (buf_we),
      .waddr  (aptr[PAGE_W-1:0]),
      .wdata  (byte_in),
      .ridx   (step_idx),
      .rdata  (buf_q),
      .rvalid (buf_vld)
   );

   write_cycle #(.WCYC_CLKS(WCYC_CLKS), .PAGE_W(PAGE_W)) u_wcyc (
      .clk      (clk),
      .rst_n    (rst_n),
      .go       (wc_go),
      .busy     (busy),
      .step_en  (step_en),
      .step_idx (step_idx)
   );

   assign mem_we = step_en && buf_vld;

   logic [ADDR_W-1:0] commit_addr;
   logic [MEM_AW-1:0] mem_wa, mem_ra;
   assign commit_addr = {cbase, step_idx};

   if (MEM_AW == ADDR_W) begin : g_full_map
      assign mem_wa = commit_addr;
      assign mem_ra = aptr;
   end else begin : g_alias_map
      logic unused_hi_bits;
      assign mem_wa = commit_addr[MEM_AW-1:0];
      assign mem_ra = aptr[MEM_AW-1:0];
      assign unused_hi_bits = ^commit_addr[ADDR_W-1:MEM_AW];
   end

   byte_mem #(.AW(MEM_AW), .DW(DATA_W)) u_mem (
      .clk   (clk),
      .we    (mem_we),
      .waddr (mem_wa),
      .wdata (buf_q),
      .raddr (mem_ra),
      .rdata (rd_q)
   );
endmodule

// File: rtl/eeprom_slave_chk.sv
module eeprom_slave_chk #(
   parameter int WCYC_CLKS = 1250000
) (
   input logic clk,
   input logic rst_n,
   input logic scl_s,
   input logic sda_oe,
   input logic busy,
   input logic stop_det,
   input logic mem_we
);
   int unsigned busy_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    busy_run <= 0;
      else if (busy) busy_run <= busy_run + 1;
      else           busy_run <= 0;
   end

   // R3: data-line drive moves only while the bus clock is low
   assert_sda_moves_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (sda_oe != $past(sda_oe)) |-> !scl_s);

   // R6: no acknowledge or data is driven during a write cycle
   assert_busy_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !sda_oe);

   // R6: a write cycle begins only right after a STOP
   assert_busy_after_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(stop_det));

   // R5: the array is written only inside a write cycle
   assert_commit_in_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> busy);

   // R6: the write cycle lasts exactly WCYC_CLKS clocks
   assert_busy_length_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (busy_run == WCYC_CLKS));

   assert_busy_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
      busy_run <= WCYC_CLKS);
endmodule

bind i2c_eeprom_slave eeprom_slave_chk #(.WCYC_CLKS(WCYC_CLKS)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .scl_s    (scl_s),
   .sda_oe   (sda_oe_o),
   .busy     (busy),
   .stop_det (stop_det),
   .mem_we   (mem_we)
);

// File: tb/i2c_eeprom_slave_bench.sv
module i2c_eeprom_slave_bench;
   localparam int H   = 8;
   localparam int WC  = 300;
   localparam int PW  = 3;
   localparam int MAW = 9;
   localparam int MSZ = 1 << MAW;
   localparam logic [2:0] STRAP = 3'b101;
   localparam logic [7:0] DEVW  = {4'b1010, STRAP, 1'b0};
   localparam logic [7:0] DEVR  = {4'b1010, STRAP, 1'b1};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic m_scl = 1'b1;
   logic m_low = 1'b0;
   logic wp = 1'b0;
   logic sda_oe;
   logic sda_bus;

   assign sda_bus = ~(m_low | sda_oe);

   always #2 clk = ~clk;

   i2c_eeprom_slave #(.MEM_AW(MAW), .PAGE_W(PW), .WCYC_CLKS(WC), .SYNC_STAGES(2))
   u_i2c_eeprom_slave (
      .clk          (clk),
      .rst_n        (rst_n),
      .scl_i        (m_scl),
      .sda_i        (sda_bus),
      .sda_oe_o     (sda_oe),
      .strap_i      (STRAP),
      .wr_protect_i (wp)
   );

   int n_cmp = 0;
   int n_bad = 0;
   int r3_viol = 0;
   logic prev_oe = 1'b0;
   logic [7:0]  model [MSZ];
   logic [15:0] ptr_exp = 16'h0000;

   always @(negedge clk) begin
      if (rst_n && (sda_oe !== prev_oe) && m_scl) r3_viol++;
      prev_oe = sda_oe;
   end

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic chk(input string tag, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic bus_start();
      m_scl = 1'b0; tick(2);
      m_low = 1'b0; tick(H);
      m_scl = 1'b1; tick(H);
      m_low = 1'b1; tick(H);
      m_scl = 1'b0; tick(2);
   endtask

   task automatic bus_stop();
      m_low = 1'b1; tick(H);
      m_scl = 1'b1; tick(H);
      m_low = 1'b0; tick(H);
   endtask

   task automatic clock_bit(input logic drive_low, output logic seen);
      m_low = drive_low; tick(H);
      m_scl = 1'b1; tick(H / 2);
      seen = sda_bus; tick(H / 2);
      m_scl = 1'b0; tick(2);
   endtask

   task automatic send_byte(input logic [7:0] b, output logic acked);
      logic s;
      for (int i = 7; i >= 0; i--) clock_bit(~b[i], s);
      clock_bit(1'b0, s);
      acked = ~s;
   endtask

   task automatic recv_byte(input logic give_ack, output logic [7:0] b);
      logic s;
      for (int i = 7; i >= 0; i--) begin
         clock_bit(1'b0, s);
         b[i] = s;
      end
      clock_bit(give_ack, s);
   endtask

   task automatic poll(output logic acked);
      bus_start();
      send_byte(DEVW, acked);
      bus_stop();
   endtask

   task automatic wr_txn(input logic [15:0] a, input int n, input logic [7:0] first,
                         input logic [7:0] step, input string tag);
      logic ack;
      logic [7:0] d;
      bus_start();
      send_byte(DEVW, ack);     chk(tag, int'(ack), 1);
      send_byte(a[15:8], ack);  chk(tag, int'(ack), 1);
      send_byte(a[7:0], ack);   chk(tag, int'(ack), 1);
      for (int k = 0; k < n; k++) begin
         d = first + 8'(k) * step;
         send_byte(d, ack);
         chk(tag, int'(ack), wp ? 0 : 1);
         if (wp) break;
         model[int'({a[15:PW], PW'(a[PW-1:0] + PW'(k))} & 16'(MSZ - 1))] = d;
      end
      bus_stop();
      if (!wp) ptr_exp = {a[15:PW], PW'(a[PW-1:0] + PW'(n))};
   endtask

   task automatic rd_txn(input logic [15:0] a, input int n, input string tag);
      logic ack;
      logic [7:0] b;
      bus_start();
      send_byte(DEVW, ack);     chk(tag, int'(ack), 1);
      send_byte(a[15:8], ack);  chk(tag, int'(ack), 1);
      send_byte(a[7:0], ack);   chk(tag, int'(ack), 1);
      bus_start();
      send_byte(DEVR, ack);     chk(tag, int'(ack), 1);
      for (int k = 0; k < n; k++) begin
         recv_byte(k < n - 1, b);
         chk(tag, int'(b), int'(model[int'((a + 16'(k)) & 16'(MSZ - 1))]));
      end
      bus_stop();
      ptr_exp = a + 16'(n);
   endtask

   task automatic cur_rd(input int n, input string tag);
      logic ack;
      logic [7:0] b;
      bus_start();
      send_byte(DEVR, ack);     chk(tag, int'(ack), 1);
      for (int k = 0; k < n; k++) begin
         recv_byte(k < n - 1, b);
         chk(tag, int'(b), int'(model[int'((ptr_exp + 16'(k)) & 16'(MSZ - 1))]));
      end
      bus_stop();
      ptr_exp = ptr_exp + 16'(n);
   endtask

   task automatic wait_wc();
      tick(WC + 40);
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_cmp++;
      n_bad++;
      $display("FAIL R6 watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      logic ack;
      logic [15:0] a;
      tick(5);
      rst_n = 1'b1;
      tick(4);

      // R1: reset state
      chk("R1 enable", int'(sda_oe), 0);
      chk("R1 line", int'(sda_bus), 1);
      poll(ack);
      chk("R1 first select", int'(ack), 1);

      // R2: strap and type sweeps
      for (int s = 0; s < 8; s++) begin
         bus_start();
         send_byte({4'b1010, 3'(s), 1'b0}, ack);
         bus_stop();
         chk("R2 strap", int'(ack), (3'(s) == STRAP) ? 1 : 0);
      end
      for (int t = 0; t < 16; t++) begin
         bus_start();
         send_byte({4'(t), STRAP, 1'b0}, ack);
         bus_stop();
         chk("R2 type", int'(ack), (4'(t) == 4'b1010) ? 1 : 0);
      end
      bus_start();
      send_byte(8'hA0, ack);   chk("R2 foreign", int'(ack), 0);
      send_byte(8'h00, ack);   chk("R2 ignored", int'(ack), 0);
      send_byte(8'h10, ack);   chk("R2 ignored", int'(ack), 0);
      bus_stop();

      // R4/R6: byte write, busy poll, random read
      wr_txn(16'h0123, 1, 8'h5A, 8'h00, "R4");
      poll(ack);
      chk("R6 busy poll", int'(ack), 0);
      tick(WC);
      poll(ack);
      chk("R6 done poll", int'(ack), 1);
      rd_txn(16'h0123, 1, "R4");

      // R5: page writes from every offset, lengths 3..10 in an 8-byte page
      for (int off = 0; off < 8; off++) begin
         a = 16'h0100 + 16'(off * 8 + off);
         wr_txn(a, 3 + off, 8'(16 * off), 8'd3, "R5");
         wait_wc();
         if (off == 7) cur_rd(1, "R9");
         rd_txn(a & 16'hFFF8, 8, "R5");
      end

      // R7: write control blocks data
      wp = 1'b1;
      wr_txn(16'h0123, 1, 8'hFF, 8'h00, "R7");
      wp = 1'b0;
      poll(ack);
      chk("R7 no cycle", int'(ack), 1);
      rd_txn(16'h0123, 1, "R7");

      // R8: address-only write
      bus_start();
      send_byte(DEVW, ack);   chk("R8", int'(ack), 1);
      send_byte(8'h01, ack);  chk("R8", int'(ack), 1);
      send_byte(8'h23, ack);  chk("R8", int'(ack), 1);
      bus_stop();
      poll(ack);
      chk("R8 no cycle", int'(ack), 1);

      // R11: repeated START discards pending data
      bus_start();
      send_byte(DEVW, ack);   chk("R11", int'(ack), 1);
      send_byte(8'h01, ack);  chk("R11", int'(ack), 1);
      send_byte(8'h23, ack);  chk("R11", int'(ack), 1);
      send_byte(8'h77, ack);  chk("R11", int'(ack), 1);
      bus_start();
      send_byte(DEVW, ack);   chk("R11 restart", int'(ack), 1);
      bus_stop();
      poll(ack);
      chk("R11 no cycle", int'(ack), 1);
      rd_txn(16'h0123, 1, "R11");

      // R10/R9: sequential read across 0xFFFF
      wr_txn(16'hFFFF, 1, 8'hE1, 8'h00, "R10");
      wait_wc();
      wr_txn(16'h0000, 3, 8'hE2, 8'h01, "R10");
      wait_wc();
      rd_txn(16'hFFFF, 3, "R10");
      chk("R10 released", int'(sda_oe), 0);
      cur_rd(1, "R9");

      // R3: drive changes only with SCL low
      chk("R3", r3_viol, 0);

      summary();
      $finish;
   end
endmodule